// File: doc/BRIEF.md
# Dual-Channel Serial DAC Command Front End

This block is the digital side of a two-channel 13-bit voltage DAC. A host writes 16-bit command words over a three-wire serial port made of a chip select (active low), a serial clock and a data line. The port lines are synchronised into the system clock domain and their edges are detected there. Each channel holds a staging register and an output register, so a host can prepare both channels and then switch them together, or update one channel alone. The block drives two 13-bit codes toward the converter, a powered-down flag, a user logic pin, and a chained serial output that lets several devices share one chip select.

A command word has its three most significant bits as the operation and its low 13 bits as the payload, sent most significant bit first. Operation 000 loads staging A. Operation 001 loads staging B. Operation 010 loads staging A and output A. Operation 011 loads staging B and output B. Operation 100 copies both staging registers into both output registers. Operation 101 requests power-down. Operation 110 sets the user pin to payload bit 0 and the chained-output edge mode to payload bit 1. Operation 111 does nothing. The serial port has no back-pressure: words arrive at the host's pace, and the block accepts every one of them.

Top module: `dual_dac_frontend`

## Requirements
- R1: A word executes only when chip select rises. Serial clock edges while chip select is high shift nothing.
- R2: Operations 000 and 001 change no output code.
- R3: Operation 010 sets code_a to the payload, and 011 sets code_b to the payload. The other channel's code is unchanged.
- R4: Operation 100 moves both staging values to code_a and code_b together.
- R5: While clear_n is low, code_a, code_b, user_pin, powered_down and chain_out are 0 at once, without a clock. Staging, output, mode and shift state return to their reset values.
- R6: After reset, every output is 0, chain mode is the rising mode, and both staging registers hold 0.
- R7: In rising mode (mode bit 0), chain_out takes the new most significant shift-register bit after each serial clock rise.
- R8: In falling mode (mode bit 1), chain_out holds its value through the rise and takes the most significant shift-register bit after the following serial clock fall.
- R9: Operation 101 with sd_lock low sets powered_down, and both codes read 0 while it is set.
- R10: While sd_lock is high, powered_down is 0, and operation 101 issued in that time is discarded.
- R11: Operations 010, 011 and 100 leave power-down, and the codes show the current output registers.
- R12: Operation 110 drives user_pin from payload bit 0.
- R13: Operation 111 changes no output.
- R14: A word of fewer or more than 16 clocks is decoded from the last 16 bits shifted in, older bits included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| clear_n | input | 1 | Clear, active low, asynchronous |
| spi_cs_n | input | 1 | Serial chip select, active low |
| spi_clk | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data in |
| sd_lock | input | 1 | Hardware lock that blocks power-down |
| chain_out | output | 1 | Serial data out for chaining |
| user_pin | output | 1 | Programmable logic output |
| powered_down | output | 1 | Effective power-down state |
| code_a | output | 13 | Code for channel A |
| code_b | output | 13 | Code for channel B |

## Verification
The bench builds the block with its default values: a 13-bit code, a 16-bit word and a two-stage synchroniser. This makes the full code range reachable, including the top code 0x1FFF. Serial half-periods of five system clocks give the synchroniser time to settle, so the chained output can be checked after every serial edge in both edge modes. Words of 8 and 20 clocks reach the truncation rule.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  typedef enum logic [2:0] {
    OP_LDIN_A  = 3'b000,
    OP_LDIN_B  = 3'b001,
    OP_LDUP_A  = 3'b010,
    OP_LDUP_B  = 3'b011,
    OP_UPD_ALL = 3'b100,
    OP_SLEEP   = 3'b101,
    OP_PIN     = 3'b110,
    OP_NOP     = 3'b111
  } op_e;
  localparam int OP_W = 3;
endpackage

// File: rtl/serial_capture.sv
module serial_capture #(
  parameter int FRAME = 16,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             din,
  input  logic             fall_mode,
  output logic [FRAME-1:0] frame,
  output logic             exec,
  output logic             chain_out
);
  logic [SYNC:0] cs_p, ck_p, dt_p;
  logic cs_lvl, ck_rise, ck_fall;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cs_p <= '1;
      ck_p <= '0;
      dt_p <= '0;
    end else begin
      cs_p <= {cs_p[SYNC-1:0], cs_n};
      ck_p <= {ck_p[SYNC-1:0], sclk};
      dt_p <= {dt_p[SYNC-1:0], din};
    end
  end

  assign cs_lvl  = cs_p[SYNC-1];
  assign ck_rise = ck_p[SYNC-1] & ~ck_p[SYNC];
  assign ck_fall = ~ck_p[SYNC-1] & ck_p[SYNC];
  assign exec    = cs_lvl & ~cs_p[SYNC];

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      frame     <= '0;
      chain_out <= 1'b0;
    end else if (!cs_lvl) begin
      if (ck_rise) frame <= {frame[FRAME-2:0], dt_p[SYNC-1]};
      if (!fall_mode && ck_rise) chain_out <= frame[FRAME-2];
      else if (fall_mode && ck_fall) chain_out <= frame[FRAME-1];
    end
  end

  // R1
  idle_no_shift_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $past(cs_lvl) |-> $stable(frame));
endmodule

// File: rtl/dac_chan.sv
module dac_chan
  import dacfe_pkg::*;
#(
  parameter int DW  = 13,
  parameter int IDX = 0
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          exec,
  input  logic [2:0]    op,
  input  logic [DW-1:0] data,
  output logic [DW-1:0] dac_q
);
  localparam logic CH = (IDX % 2) == 1;
  logic [DW-1:0] in_q;
  logic ld_in, ld_own, ld_all;

  assign ld_in  = exec && (op == {2'b00, CH} || op == {2'b01, CH});
  assign ld_own = exec && (op == {2'b01, CH});
  assign ld_all = exec && (op == OP_UPD_ALL);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      in_q  <= '0;
      dac_q <= '0;
    end else begin
      if (ld_in) in_q <= data;
      if (ld_own) dac_q <= data;
      else if (ld_all) dac_q <= in_q;
    end
  end

  // R2
  stage_only_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (exec && op == {2'b00, CH}) |=> $stable(dac_q));
  // R3
  direct_load_chk: assert property (@(posedge clk) disable iff (!arst_n)
    ld_own |=> dac_q == $past(data));
endmodule

// File: rtl/mode_ctrl.sv
module mode_ctrl
  import dacfe_pkg::*;
(
  input  logic       clk,
  input  logic       arst_n,
  input  logic       exec,
  input  logic [2:0] op,
  input  logic [1:0] arg,
  input  logic       lock,
  output logic       sleep_q,
  output logic       pin_q,
  output logic       fall_q
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sleep_q <= 1'b0;
      pin_q   <= 1'b0;
      fall_q  <= 1'b0;
    end else if (exec) begin
      unique case (op)
        OP_SLEEP:  if (!lock) sleep_q <= 1'b1;
        OP_LDUP_A, OP_LDUP_B, OP_UPD_ALL: sleep_q <= 1'b0;
        OP_PIN: begin
          pin_q  <= arg[0];
          fall_q <= arg[1];
        end
        default: ;
      endcase
    end
  end

  // R11
  wake_on_update_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (exec && (op == OP_UPD_ALL || op == OP_LDUP_A || op == OP_LDUP_B)) |=> !sleep_q);
  // R10
  locked_sleep_block_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (exec && lock && op == OP_SLEEP) |=> sleep_q == $past(sleep_q));
endmodule

// File: rtl/dual_dac_frontend.sv
module dual_dac_frontend
  import dacfe_pkg::*;
#(
  parameter int DW   = 13,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_n,
  input  logic          spi_cs_n,
  input  logic          spi_clk,
  input  logic          spi_mosi,
  input  logic          sd_lock,
  output logic          chain_out,
  output logic          user_pin,
  output logic          powered_down,
  output logic [DW-1:0] code_a,
  output logic [DW-1:0] code_b
);
  localparam int FRAME = DW + OP_W;

  logic             arst_n;
  logic [FRAME-1:0] frame;
  logic             exec, sleep_q, fall_q;
  logic [2:0]       op;
  logic [DW-1:0]    dac_w [2];

  assign arst_n = rst_n & clear_n;
  assign op     = frame[FRAME-1 -: OP_W];

  serial_capture #(.FRAME(FRAME), .SYNC(SYNC)) u_cap (
    .clk(clk), .arst_n(arst_n), .cs_n(spi_cs_n), .sclk(spi_clk), .din(spi_mosi),
    .fall_mode(fall_q), .frame(frame), .exec(exec), .chain_out(chain_out));

  for (genvar g = 0; g < 2; g++) begin : g_ch
    dac_chan #(.DW(DW), .IDX(g)) u_ch (
      .clk(clk), .arst_n(arst_n), .exec(exec), .op(op),
      .data(frame[DW-1:0]), .dac_q(dac_w[g]));
  end

  mode_ctrl u_mode (
    .clk(clk), .arst_n(arst_n), .exec(exec), .op(op), .arg(frame[1:0]),
    .lock(sd_lock), .sleep_q(sleep_q), .pin_q(user_pin), .fall_q(fall_q));

  assign powered_down = sleep_q & ~sd_lock;
  assign code_a = powered_down ? '0 : dac_w[0];
  assign code_b = powered_down ? '0 : dac_w[1];

  // R9
  sleep_zero_chk: assert property (@(posedge clk) disable iff (!arst_n)
    powered_down |-> (code_a == '0 && code_b == '0));
  // R10
  lock_awake_chk: assert property (@(posedge clk) disable iff (!arst_n)
    sd_lock |-> !powered_down);
endmodule

// File: tb/sim_dual_dac_frontend.sv
module sim_dual_dac_frontend;
  logic clk = 0, rst_n = 0, clear_n = 1, cs_n = 1, sck = 0, mosi = 0, lock = 0;
  logic chain_out, user_pin, powered_down;
  logic [12:0] code_a, code_b;
  int checks = 0, fails = 0, cycles = 0;

  // reference model state
  logic [15:0] m_sr = 0;
  logic [12:0] m_in_a = 0, m_in_b = 0, m_dac_a = 0, m_dac_b = 0;
  logic m_sleep = 0, m_pin = 0, m_fall = 0, m_chain = 0;

  always #2.5 clk = ~clk;

  dual_dac_frontend u0 (
    .clk(clk), .rst_n(rst_n), .clear_n(clear_n), .spi_cs_n(cs_n), .spi_clk(sck),
    .spi_mosi(mosi), .sd_lock(lock), .chain_out(chain_out), .user_pin(user_pin),
    .powered_down(powered_down), .code_a(code_a), .code_b(code_b));

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      fails++;
      $display("FAIL watchdog: run did not finish, got timeout exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %h exp %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic pd;
    pd = m_sleep & ~lock;
    chk(tag, "code_a", code_a, pd ? 0 : m_dac_a);
    chk(tag, "code_b", code_b, pd ? 0 : m_dac_b);
    chk(tag, "powered_down", powered_down, pd);
    chk(tag, "user_pin", user_pin, m_pin);
  endtask

  task automatic model_exec();
    logic [2:0] op;
    logic [12:0] d;
    op = m_sr[15:13];
    d = m_sr[12:0];
    case (op)
      3'b000: m_in_a = d;
      3'b001: m_in_b = d;
      3'b010: begin m_in_a = d; m_dac_a = d; m_sleep = 0; end
      3'b011: begin m_in_b = d; m_dac_b = d; m_sleep = 0; end
      3'b100: begin m_dac_a = m_in_a; m_dac_b = m_in_b; m_sleep = 0; end
      3'b101: if (!lock) m_sleep = 1;
      3'b110: begin m_pin = d[0]; m_fall = d[1]; end
      default: ;
    endcase
  endtask

  task automatic half_wait();
    repeat (5) @(negedge clk);
  endtask

  // shift n bits, msb first, checking the chained output after every edge
  task automatic send(input string tag, input int n, input logic [31:0] bits);
    cs_n = 0;
    half_wait();
    for (int i = n - 1; i >= 0; i--) begin
      mosi = bits[i];
      half_wait();
      sck = 1;
      m_sr = {m_sr[14:0], bits[i]};
      if (!m_fall) m_chain = m_sr[15];
      half_wait();
      chk(tag, "chain_out after rise", chain_out, m_chain);
      sck = 0;
      if (m_fall) m_chain = m_sr[15];
      half_wait();
      chk(tag, "chain_out after fall", chain_out, m_chain);
    end
    cs_n = 1;
    repeat (10) @(negedge clk);
    model_exec();
  endtask

  task automatic word(input string tag, input logic [2:0] op, input logic [12:0] d);
    send(tag, 16, {16'h0, op, d});
    check_all(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R6 reset state
    chk("R6", "code_a", code_a, 0);
    chk("R6", "code_b", code_b, 0);
    chk("R6", "chain_out", chain_out, 0);
    chk("R6", "user_pin", user_pin, 0);
    chk("R6", "powered_down", powered_down, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    word("R2", 3'b000, 13'h0ABC);
    word("R3", 3'b011, 13'h1FFF);
    word("R3", 3'b010, 13'h0001);
    word("R2", 3'b001, 13'h0123);
    word("R4", 3'b100, 13'h0000);
    word("R13", 3'b111, 13'h1FFF);
    word("R12", 3'b110, 13'h0001);
    word("R8", 3'b110, 13'h0003);
    word("R8", 3'b000, 13'h0555);
    word("R8", 3'b001, 13'h1AAA);
    word("R7", 3'b110, 13'h0000);
    word("R7", 3'b000, 13'h1234);
    word("R12", 3'b110, 13'h0001);

    word("R9", 3'b101, 13'h0000);
    word("R11", 3'b010, 13'h0777);
    lock = 1;
    word("R10", 3'b101, 13'h0000);
    lock = 0;
    repeat (2) @(negedge clk);
    check_all("R10");
    word("R9", 3'b101, 13'h0000);
    lock = 1;
    repeat (2) @(negedge clk);
    check_all("R10");
    lock = 0;
    repeat (2) @(negedge clk);
    check_all("R9");
    word("R11", 3'b100, 13'h0000);

    // R1: clocks with chip select high shift nothing
    for (int k = 0; k < 6; k++) begin
      mosi = 1; half_wait(); sck = 1; half_wait(); sck = 0; half_wait();
    end
    cs_n = 0; half_wait(); cs_n = 1;
    repeat (10) @(negedge clk);
    model_exec();
    check_all("R1");

    // R14: long and short words
    send("R14", 20, {12'h0, 4'hF, 3'b011, 13'h0456});
    check_all("R14");
    send("R14", 8, {24'h0, 8'h21});
    check_all("R14");
    word("R14", 3'b100, 13'h0000);

    // R5: asynchronous clear
    word("R5", 3'b110, 13'h0001);
    @(posedge clk); #1;
    clear_n = 0;
    #0.5;
    chk("R5", "code_a", code_a, 0);
    chk("R5", "code_b", code_b, 0);
    chk("R5", "user_pin", user_pin, 0);
    chk("R5", "chain_out", chain_out, 0);
    chk("R5", "powered_down", powered_down, 0);
    m_sr = 0; m_in_a = 0; m_in_b = 0; m_dac_a = 0; m_dac_b = 0;
    m_sleep = 0; m_pin = 0; m_fall = 0; m_chain = 0;
    repeat (3) @(negedge clk);
    clear_n = 1;
    repeat (3) @(negedge clk);
    word("R5", 3'b100, 13'h0000);
    word("R7", 3'b011, 13'h0042);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule